// File: doc/BRIEF.md
# Tick-Paced I2C Master Bit Engine

This block generates I2C master bus activity: start conditions, stop conditions, byte writes and byte reads. It never advances on its own. Each bus action moves forward only on a clock cycle where the shared `tick` strobe is high, so the engine can share one timebase with other logic on the chip. Every SCL period takes exactly four ticks. A 100 kbps bus therefore needs a 400 kHz tick, and in general the tick runs at four times the bit rate.

Both bus lines are handled open-drain style. A drive-enable output of 1 pulls its line low, and a drive-enable of 0 releases the line to the external pull-up. The SDA level is read back through `sda_in`. A command is taken through a small command port. When the command finishes, `rsp_valid` pulses for one cycle, with the byte on `rsp_data` and the sampled acknowledge bit on `rsp_ack`. Bus arbitration and clock stretching are not handled: SCL is never read back.

Top module: `i2c_tick_master`

## Requirements
- R1: After reset, both drive enables are 0 (lines released), `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: While no tick arrives, `scl_oe` and `sda_oe` keep their values, even while a command is in progress.
- R3: Each bit slot uses four consecutive ticks in this order. Tick 1 sets `scl_oe`=1. Tick 2 updates `sda_oe`. Tick 3 sets `scl_oe`=0. Tick 4 leaves SCL as it is, and for byte commands also leaves SDA as it is. A byte command completes on its 36th tick, and a start or stop command on its 4th tick. `rsp_valid` is high in the cycle after the clock edge that consumed that tick.
- R4: For byte commands, `sda_oe` changes only while `scl_oe` is 1. The only SDA edges seen on the bus while SCL is high are the ones made by start and stop commands.
- R5: A start command (`cmd_op`=0) releases SDA on tick 2 and releases SCL on tick 3. On tick 4 it pulls SDA low while SCL stays high. The next command pulls SCL low on its first tick. This works both from an idle bus and as a repeated start.
- R6: A stop command (`cmd_op`=1) pulls SDA low on tick 2, while SCL is low. On tick 4 it releases SDA while SCL is high, which leaves both lines released.
- R7: A write (`cmd_op`=2) sends `cmd_data` MSB first over 8 bit slots. It releases SDA for a ninth slot and samples SDA on tick 4 of that slot. The sampled level goes to `rsp_ack`, where 0 means the slave acknowledged. `rsp_data` returns the 8 SDA levels read back during the data slots.
- R8: A read (`cmd_op`=3) releases SDA for 8 slots and samples SDA on each tick 4. The samples build `rsp_data` MSB first. In the ninth slot the engine pulls SDA low if `cmd_nack`=0, or releases it if `cmd_nack`=1. `rsp_ack` reports the level sampled in that slot.
- R9: `cmd_ready` is 1 only when no command is in progress. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_valid` has no effect while a command is in progress.
- R10: `rsp_valid` is a single-cycle pulse, with exactly one pulse per command taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Base tick strobe, one cycle wide, at four times the bit rate |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_data | input | DATA_W | Byte to write |
| cmd_nack | input | 1 | Read only: 1 releases SDA in the ninth slot, 0 pulls it low |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level read back |
| rsp_valid | output | 1 | Command finished, one-cycle pulse |
| rsp_data | output | DATA_W | Byte read, or the bits read back during a write |
| rsp_ack | output | 1 | SDA level sampled in the ninth slot |

## Verification
Each output moves one clock after the edge that consumed a tick. The bench therefore counts, at every falling clock edge, the ticks the engine will take at the next rising edge. It checks the line state of each phase one falling edge after that phase's tick, and expects `rsp_valid` at the falling edge after the 4th or the 36th tick of a command. `cmd_ready` is checked at the falling edge after the accepting edge. Bus-level start and stop events, and the bits on the wire, are decoded from the line levels at every falling edge. A scoreboard pairs each `rsp_valid` pulse with the expected result that the command driver queued.

// File: rtl/i2c_tick_pkg.sv
// Shared definitions for the tick-paced I2C master.
// Assumes a four-phase bit slot; the phase codes are used by the sequencer
// and by the line-control logic in the top module.
package i2c_tick_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } i2c_op_e;

    localparam int PH_W = 2;
    localparam logic [PH_W-1:0] PH_SCL_LOW  = 2'd0;
    localparam logic [PH_W-1:0] PH_SDA_SET  = 2'd1;
    localparam logic [PH_W-1:0] PH_SCL_HIGH = 2'd2;
    localparam logic [PH_W-1:0] PH_HOLD     = 2'd3;
endpackage

// File: rtl/i2c_phase_seq.sv
// Phase and bit-slot counter.
// Counts tick phases within a bit slot and bit slots within a command.
// Assumes 'restart' and 'advance' are never high in the same cycle.
module i2c_phase_seq #(
    parameter int PH_W  = 2,
    parameter int BIT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [BIT_W-1:0] last_bit,
    output logic [PH_W-1:0]  phase,
    output logic [BIT_W-1:0] bit_idx,
    output logic             final_step
);
    localparam logic [PH_W-1:0] PH_LAST = '1;

    // Step the phase on each tick; roll into the next bit slot after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            bit_idx <= '0;
        end else if (restart) begin
            phase   <= '0;
            bit_idx <= '0;
        end else if (advance) begin
            if (phase == PH_LAST) begin
                phase   <= '0;
                bit_idx <= bit_idx + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // Flag the tick that closes the final bit slot of the command.
    always_comb begin
        final_step = advance && (phase == PH_LAST) && (bit_idx == last_bit);
    end
endmodule

// File: rtl/i2c_shift_reg.sv
// Byte shift register, MSB first.
// Loads the byte to send and shifts the sampled SDA in at the LSB,
// so after a full byte it holds the bits seen on the wire.
module i2c_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             in_bit,
    output logic [WIDTH-1:0] value,
    output logic             msb
);
    // Load on command accept; shift one bit per data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (shift) begin
            value <= {value[WIDTH-2:0], in_bit};
        end
    end

    // Present the bit due next on the wire.
    always_comb begin
        msb = value[WIDTH-1];
    end
endmodule

// File: rtl/i2c_tick_master.sv
// Tick-paced I2C master bit engine.
// Runs start, stop, byte write and byte read commands. Each bit slot is four
// ticks: SCL low, SDA set, SCL release, hold. Assumes open-drain lines with
// external pull-ups, no other master, and no clock stretching.
module i2c_tick_master #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_nack,
    output logic              cmd_ready,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_ack
);
    import i2c_tick_pkg::*;

    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [BIT_W-1:0] BYTE_LAST = BIT_W'(DATA_W);

    logic             busy_q;
    i2c_op_e          op_q;
    logic             nack_q;
    logic             accept;
    logic             step;
    logic [PH_W-1:0]  phase;
    logic [BIT_W-1:0] bit_idx;
    logic [BIT_W-1:0] last_bit;
    logic             final_step;
    logic             byte_op;
    logic             data_slot;
    logic             sda_drive;
    logic             do_shift;
    logic             sh_msb;

    // Decode the handshake, the tick-qualified step and the current slot type.
    always_comb begin
        accept    = cmd_valid && !busy_q;
        step      = busy_q && tick;
        byte_op   = (op_q == OP_WRITE) || (op_q == OP_READ);
        last_bit  = byte_op ? BYTE_LAST : '0;
        data_slot = (bit_idx != BYTE_LAST);
        do_shift  = step && byte_op && data_slot && (phase == PH_HOLD);
        cmd_ready = !busy_q;
    end

    // Choose the SDA drive enable applied on the second tick of a slot.
    always_comb begin
        unique case (op_q)
            OP_START: sda_drive = 1'b0;
            OP_STOP:  sda_drive = 1'b1;
            OP_WRITE: sda_drive = data_slot ? !sh_msb : 1'b0;
            default:  sda_drive = data_slot ? 1'b0 : !nack_q;
        endcase
    end

    i2c_phase_seq #(
        .PH_W  (PH_W),
        .BIT_W (BIT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (accept),
        .advance    (step),
        .last_bit   (last_bit),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .final_step (final_step)
    );

    i2c_shift_reg #(
        .WIDTH (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_data),
        .shift    (do_shift),
        .in_bit   (sda_in),
        .value    (rsp_data),
        .msb      (sh_msb)
    );

    // Run the command: latch it on accept, then drive the lines phase by phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            op_q      <= OP_START;
            nack_q    <= 1'b0;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_ack   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                op_q   <= i2c_op_e'(cmd_op);
                nack_q <= cmd_nack;
            end else if (step) begin
                unique case (phase)
                    PH_SCL_LOW:  scl_oe <= 1'b1;
                    PH_SDA_SET:  sda_oe <= sda_drive;
                    PH_SCL_HIGH: scl_oe <= 1'b0;
                    default: begin
                        if (op_q == OP_START) begin
                            sda_oe <= 1'b1;
                        end else if (op_q == OP_STOP) begin
                            sda_oe <= 1'b0;
                        end else if (!data_slot) begin
                            rsp_ack <= sda_in;
                        end
                        if (final_step) begin
                            busy_q    <= 1'b0;
                            rsp_valid <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_tick_master_chk.sv
// Property checker for the tick-paced I2C master, bound to every instance.
// Observes ports and the latched command code only.
module i2c_tick_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       rsp_valid,
    input logic [1:0] op_q
);
    import i2c_tick_pkg::*;

    // R2: the lines can only move on an edge that consumed a tick.
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(scl_oe) && $stable(sda_oe)));

    // R5: SDA pulled low while SCL is released only inside a start command.
    a_r5_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (op_q == OP_START));

    // R6: SDA released while SCL is released only inside a stop command.
    a_r6_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (op_q == OP_STOP));

    // R9: once a command is taken the engine reports busy.
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R10: the completion strobe lasts one cycle.
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3: completion only follows a consumed tick.
    a_r3_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(tick));
endmodule

bind i2c_tick_master i2c_tick_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .rsp_valid (rsp_valid),
    .op_q      (op_q)
);

// File: tb/i2c_tick_master_test.sv
// Scoreboard bench for the tick-paced I2C master with a simple bus slave model.
module i2c_tick_master_test;
    import i2c_tick_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] tick_cnt = 2'd0;
    logic       tick;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_data = 8'h00;
    logic       cmd_nack = 1'b0;
    logic       cmd_ready, scl_oe, sda_oe, sda_in, rsp_valid, rsp_ack;
    logic [7:0] rsp_data;

    // Slave model and bus monitor state.
    int         slave_mode = 0;      // 0 idle, 1 acknowledge a write, 2 send a byte
    int         slave_idx = 0;
    logic [7:0] slave_byte = 8'h00;
    logic       slave_ack = 1'b0;
    logic       slave_pull = 1'b0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic [8:0] wire_bits = 9'h0;
    int         n_start = 0, n_stop = 0;

    int n_checks = 0, n_fail = 0;
    logic finished = 1'b0;

    typedef struct { logic [7:0] data; logic ack; bit cmp; string req; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) tick_cnt <= tick_cnt + 2'd1;
    assign tick   = tick_en && (tick_cnt == 2'd0);
    assign sda_in = !sda_oe && !slave_pull;

    i2c_tick_master #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_nack(cmd_nack),
        .cmd_ready(cmd_ready), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ack(rsp_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bus monitor and slave: decode start/stop and wire bits, update the slave on SCL falls.
    always @(negedge clk) begin
        logic scl_l, sda_l;
        scl_l = !scl_oe;
        sda_l = sda_in;
        if (rst_n) begin
            if (scl_l && prev_scl && (sda_l != prev_sda)) begin
                if (!sda_l) n_start++;
                else        n_stop++;
            end
            if (scl_l && !prev_scl) wire_bits = {wire_bits[7:0], sda_l};
            if (!scl_l && prev_scl) begin
                if (slave_mode == 1)      slave_pull = (slave_idx == 8) ? slave_ack : 1'b0;
                else if (slave_mode == 2) slave_pull = (slave_idx < 8) ? !slave_byte[7 - slave_idx] : 1'b0;
                else                      slave_pull = 1'b0;
                slave_idx++;
            end
        end
        prev_scl = scl_l;
        prev_sda = sda_l;
    end

    // Scoreboard monitor: pop one expected result per completion pulse (R10).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.cmp) begin
                    check(rsp_data == e.data, e.req, "rsp_data", rsp_data, e.data);
                    check(rsp_ack == e.ack, e.req, "rsp_ack", rsp_ack, e.ack);
                end else begin
                    check(1'b1, "R10", "completion", 1, 1);
                end
            end
        end
    end

    // Driver: issue one command, follow its ticks, check phase order and latency (R3).
    task automatic run_cmd(input logic [1:0] op, input logic [7:0] data, input logic nack,
                           input int smode, input logic [7:0] sbyte, input logic sack,
                           input bit freeze, input bit poke);
        exp_t e;
        int   steps = 0, guard = 0, exp_steps;
        bit   pending, phase_ok = 1'b1, frozen = 1'b0;
        logic sda_mid = 1'b0;
        bit   byte_cmd;
        byte_cmd  = (op == OP_WRITE) || (op == OP_READ);
        exp_steps = byte_cmd ? 36 : 4;
        e.cmp  = byte_cmd;
        e.data = (op == OP_WRITE) ? data : sbyte;
        e.ack  = (op == OP_WRITE) ? !sack : nack;
        e.req  = (op == OP_WRITE) ? "R7" : "R8";
        exp_q.push_back(e);
        slave_mode = smode; slave_byte = sbyte; slave_ack = sack; slave_idx = 0;
        check(cmd_ready == 1'b1, "R9", "ready before command", cmd_ready, 1);
        cmd_op = op; cmd_data = data; cmd_nack = nack; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R9", "busy after accept", cmd_ready, 0);
        pending = tick;
        forever begin
            @(negedge clk);
            guard++;
            if (pending) begin
                steps++;
                case ((steps - 1) % 4)
                    0: if (scl_oe !== 1'b1) phase_ok = 1'b0;
                    1: begin if (scl_oe !== 1'b1) phase_ok = 1'b0; sda_mid = sda_oe; end
                    2: if (scl_oe !== 1'b0) phase_ok = 1'b0;
                    default: begin
                        if (scl_oe !== 1'b0) phase_ok = 1'b0;
                        if (byte_cmd && (sda_oe !== sda_mid)) phase_ok = 1'b0;
                    end
                endcase
                if (poke && steps == 5) begin
                    cmd_op = OP_READ; cmd_data = 8'h00; cmd_valid = 1'b1;
                    repeat (3) @(negedge clk);
                    cmd_valid = 1'b0;
                    check(cmd_ready == 1'b0, "R9", "still busy during poke", cmd_ready, 0);
                end
                if (freeze && steps == 10 && !frozen) begin
                    logic s_scl, s_sda;
                    frozen = 1'b1;
                    tick_en = 1'b0;
                    s_scl = scl_oe; s_sda = sda_oe;
                    repeat (40) @(negedge clk);
                    check((scl_oe == s_scl) && (sda_oe == s_sda), "R2", "lines frozen without tick",
                          {scl_oe, sda_oe}, {s_scl, s_sda});
                    tick_en = 1'b1;
                end
            end
            if (rsp_valid || guard > 3000) break;
            pending = tick;
        end
        check(rsp_valid == 1'b1, "R3", "completion seen", rsp_valid, 1);
        check(steps == exp_steps, "R3", "ticks to completion", steps, exp_steps);
        check(phase_ok, "R3", "phase order", phase_ok, 1);
        @(negedge clk);
        check(!rsp_valid && cmd_ready, "R10", "pulse ended and idle", {rsp_valid, cmd_ready}, 2'b01);
    endtask

    initial begin
        int s0, p0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(scl_oe == 1'b0, "R1", "scl_oe", scl_oe, 0);
        check(sda_oe == 1'b0, "R1", "sda_oe", sda_oe, 0);
        check(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: start from an idle bus
        s0 = n_start;
        run_cmd(OP_START, 8'h00, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
        check(n_start == s0 + 1, "R5", "start seen on bus", n_start, s0 + 1);
        check(sda_oe && !scl_oe, "R5", "SDA low, SCL high after start", {scl_oe, sda_oe}, 2'b01);

        // R7 + R2: write acknowledged, with ticks paused mid-byte
        run_cmd(OP_WRITE, 8'hA5, 1'b0, 1, 8'h00, 1'b1, 1'b1, 1'b0);
        check(wire_bits[8:1] == 8'hA5, "R7", "MSB-first bits on wire", wire_bits[8:1], 8'hA5);
        check(wire_bits[0] == 1'b0, "R7", "ack slot level", wire_bits[0], 0);

        // R7 + R9: write not acknowledged, with cmd_valid pulsed while busy
        run_cmd(OP_WRITE, 8'h3C, 1'b0, 1, 8'h00, 1'b0, 1'b0, 1'b1);
        check(wire_bits[8:1] == 8'h3C, "R9", "byte unaffected by busy poke", wire_bits[8:1], 8'h3C);
        check(exp_q.size() == 0, "R9", "no extra command taken", exp_q.size(), 0);

        // R5: repeated start
        s0 = n_start;
        run_cmd(OP_START, 8'h00, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
        check(n_start == s0 + 1, "R5", "repeated start seen", n_start, s0 + 1);

        // R8: reads with master ACK then master NACK
        run_cmd(OP_READ, 8'h00, 1'b0, 2, 8'hC3, 1'b0, 1'b0, 1'b0);
        check(wire_bits[0] == 1'b0, "R8", "master ack drives low", wire_bits[0], 0);
        run_cmd(OP_READ, 8'h00, 1'b1, 2, 8'h5A, 1'b0, 1'b0, 1'b0);
        check(wire_bits[0] == 1'b1, "R8", "master nack releases", wire_bits[0], 1);

        // R6: stop
        p0 = n_stop;
        run_cmd(OP_STOP, 8'h00, 1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0);
        check(n_stop == p0 + 1, "R6", "stop seen on bus", n_stop, p0 + 1);
        check(!sda_oe && !scl_oe, "R6", "both released", {scl_oe, sda_oe}, 2'b00);

        // R4: no SDA edge while SCL high other than the commanded ones
        check(n_start == 2, "R4", "total starts", n_start, 2);
        check(n_stop == 1, "R4", "total stops", n_stop, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule